// File: doc/BRIEF.md
# Translation Unit Control and Fault Register File

This block is the software-visible register file that sits beside an address translation unit. A simple 32-bit read/write bus lets software turn translation on and off, ask the unit to stall (block) so that its tables may be changed safely, set the table base and configuration words, program two address windows used by a prefetcher, and request TLB invalidation either of everything or of one 4 KB page.

On the translation side the block accepts single-cycle fault events, each carrying a 3-bit fault type and a 32-bit address. Every fault type owns a fixed interrupt status bit. Its address is latched into the address register for that class of fault. Any fault also stalls the unit until software writes the enable code again. The interrupt line is the OR of all pending status bits. Software clears a status bit by writing a one in its position to the clear register.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset, control, configuration, table base, window, interrupt status and fault address registers read 0. `xlat_en`, `xlat_blocked`, `irq`, `flush_all` and `flush_one` are 0. The version word at 0x034 reads 0x3000_0001, with bits 31:28 equal to 3, and writes to it are ignored.
- R2: Control (0x000) stores bits 2:0 of a write and reads them back. `xlat_en` equals bit 0 of the stored code. Code 0x5 enables translation and 0x0 disables it.
- R3: Writing 0x7 to control blocks the unit: `xlat_blocked` and status (0x008) bit 0 read 1 after the write. A later write of 0x5 returns both to 0.
- R4: A fault event blocks the unit. It stays blocked through writes of any control code other than 0x5.
- R5: A fault of type t sets interrupt status (0x018) bit t. The fault types are 0 page, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security and 7 write access. `irq` is 1 exactly when some status bit is set.
- R6: The fault address is latched according to its type. Type 0 goes to 0x024. Types 2, 6 and 7 go to 0x028. Types 1, 4 and 5 go to 0x02C. Type 3 goes to 0x030.
- R7: A fault whose type bit is already set does not change the latched address. After the bit is cleared, the next fault of that type does change it.
- R8: Writing a mask to clear (0x01C) clears the status bits that are 1 in the mask. If a fault arrives in the same cycle as a clear of its own bit, the fault wins and the bit stays set. Writes to 0x018 have no effect.
- R9: A write to flush (0x00C) with bit 0 set gives `flush_all` high for exactly one cycle. With bit 0 clear, no pulse is produced.
- R10: A write to flush-entry (0x010) with bit 0 set gives `flush_one` high for one cycle. `flush_addr` then carries write bits 31:12, with bits 11:0 equal to zero.
- R11: Configuration (0x004), table base (0x014) and the window registers are full 32-bit read/write. Window 0 has its start at 0x04C and its inclusive end at 0x050. Window 1 has its start at 0x054 and its end at 0x058.
- R12: Read data appears on `bus_rdata` in the cycle after the read request. Unmapped addresses and the two flush registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault type 0..7 |
| flt_addr | input | 32 | Address that faulted |
| xlat_en | output | 1 | Translation enabled |
| xlat_blocked | output | 1 | Unit is held in the blocked state |
| irq | output | 1 | Any interrupt status bit pending |
| flush_all | output | 1 | One-cycle full invalidate request |
| flush_one | output | 1 | One-cycle single-page invalidate request |
| flush_addr | output | 32 | Page address for the single-page invalidate |

## Verification
The hardest situation to reach is the collision of a fault with a clear of the same status bit in one cycle, together with a repeat fault that lands on a shared address register while a sibling type is still pending. Directed steps drive a fault and a clear on the same edge. A long seeded random run then mixes faults of all eight types, partial clear masks and read-backs, so that shared slots are overwritten and protected in many orders. Every read is compared against a bench model of the status and address registers.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int unsigned OFF_CTRL   = 32'h000;
  localparam int unsigned OFF_CFG    = 32'h004;
  localparam int unsigned OFF_STAT   = 32'h008;
  localparam int unsigned OFF_FLUSH  = 32'h00C;
  localparam int unsigned OFF_FENTRY = 32'h010;
  localparam int unsigned OFF_PTBASE = 32'h014;
  localparam int unsigned OFF_ISTAT  = 32'h018;
  localparam int unsigned OFF_ICLR   = 32'h01C;
  localparam int unsigned OFF_FADDR0 = 32'h024;
  localparam int unsigned OFF_VER    = 32'h034;
  localparam int unsigned OFF_WIN0   = 32'h04C;

  localparam int unsigned NUM_FTYPES = 8;
  localparam int unsigned NUM_SLOTS  = 4;

  localparam logic [2:0] CODE_OFF   = 3'h0;
  localparam logic [2:0] CODE_ON    = 3'h5;
  localparam logic [2:0] CODE_BLOCK = 3'h7;

  // slot 0: page, 1: write channel, 2: read channel, 3: bus error
  function automatic logic [1:0] fault_slot(input logic [2:0] t);
    case (t)
      3'd0:             fault_slot = 2'd0;
      3'd2, 3'd6, 3'd7: fault_slot = 2'd1;
      3'd3:             fault_slot = 2'd3;
      default:          fault_slot = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/mmu_ctl_state.sv
module mmu_ctl_state
  import mmu_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        flush_we,
  input  logic        fentry_we,
  input  logic [31:0] wdata,
  input  logic        flt_valid,
  output logic [2:0]  ctrl_q,
  output logic        blocked,
  output logic        xlat_en,
  output logic        flush_all,
  output logic        flush_one,
  output logic [31:0] flush_addr
);
  logic wr_on, wr_block;
  assign wr_on    = ctrl_we && (wdata[2:0] == CODE_ON);
  assign wr_block = ctrl_we && (wdata[2:0] == CODE_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CODE_OFF;
      blocked    <= 1'b0;
      flush_all  <= 1'b0;
      flush_one  <= 1'b0;
      flush_addr <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata[2:0];
      if (flt_valid)     blocked <= 1'b1;
      else if (wr_on)    blocked <= 1'b0;
      else if (wr_block) blocked <= 1'b1;
      flush_all <= flush_we && wdata[0];
      flush_one <= fentry_we && wdata[0];
      if (fentry_we && wdata[0]) flush_addr <= {wdata[31:12], 12'h000};
    end
  end

  assign xlat_en = ctrl_q[0];

  // R3
  block_req_chk: assert property (@(posedge clk) disable iff (rst)
    wr_block |=> blocked);
  // R4
  block_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blocked && !wr_on) |=> blocked);
  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !flush_all || $past(flush_we));
  // R10
  flush_page_chk: assert property (@(posedge clk) disable iff (rst)
    flush_one |-> (flush_addr[11:0] == 12'h000));
endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_regs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flt_valid,
  input  logic [2:0]                  flt_type,
  input  logic [31:0]                 flt_addr,
  input  logic                        clr_we,
  input  logic [NUM_FTYPES-1:0]       clr_mask,
  output logic [NUM_FTYPES-1:0]       status,
  output logic [NUM_SLOTS-1:0][31:0]  addr_q,
  output logic                        irq
);
  logic [NUM_FTYPES-1:0] set_vec, clr_vec, status_nxt;
  logic [1:0] slot;
  logic       fresh;

  assign set_vec    = flt_valid ? (NUM_FTYPES'(1) << flt_type) : '0;
  assign clr_vec    = clr_we ? clr_mask : '0;
  assign status_nxt = (status & ~clr_vec) | set_vec;
  assign slot       = fault_slot(flt_type);
  assign fresh      = flt_valid && !status[flt_type];

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      irq    <= |status_nxt;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) addr_q[s] <= '0;
      else if (fresh && (slot == 2'(s))) addr_q[s] <= flt_addr;
    end
  end

  // R5
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|status));
  // R5
  set_bit_chk: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> status[$past(flt_type)]);
  // R7
  keep_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_type == 3'd0 && status[0]) |=> $stable(addr_q[0]));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !flt_valid) |=> ((status & $past(clr_mask)) == '0));
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          NUM_WIN = 2,
  parameter logic [27:0] VER_LOW = 28'h000_0001
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic [2:0]        flt_type,
  input  logic [31:0]       flt_addr,
  output logic              xlat_en,
  output logic              xlat_blocked,
  output logic              irq,
  output logic              flush_all,
  output logic              flush_one,
  output logic [31:0]       flush_addr
);
  localparam logic [31:0] VERSION = {4'h3, VER_LOW};
  localparam int NUM_WREG = 2 * NUM_WIN;

  logic wr, rd;
  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    hit = (a == ADDR_W'(off));
  endfunction

  logic [2:0]                     ctrl_q;
  logic [NUM_FTYPES-1:0]          istat;
  logic [NUM_SLOTS-1:0][31:0]     faddr;
  logic [31:0]                    cfg_q, ptbase_q;
  logic [NUM_WREG-1:0][31:0]      win_q;

  mmu_ctl_state u_ctl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (wr && hit(bus_addr, OFF_CTRL)),
    .flush_we   (wr && hit(bus_addr, OFF_FLUSH)),
    .fentry_we  (wr && hit(bus_addr, OFF_FENTRY)),
    .wdata      (bus_wdata),
    .flt_valid  (flt_valid),
    .ctrl_q     (ctrl_q),
    .blocked    (xlat_blocked),
    .xlat_en    (xlat_en),
    .flush_all  (flush_all),
    .flush_one  (flush_one),
    .flush_addr (flush_addr)
  );

  mmu_fault_log u_flt (
    .clk       (clk),
    .rst       (rst),
    .flt_valid (flt_valid),
    .flt_type  (flt_type),
    .flt_addr  (flt_addr),
    .clr_we    (wr && hit(bus_addr, OFF_ICLR)),
    .clr_mask  (bus_wdata[NUM_FTYPES-1:0]),
    .status    (istat),
    .addr_q    (faddr),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      ptbase_q <= '0;
    end else begin
      if (wr && hit(bus_addr, OFF_CFG))    cfg_q    <= bus_wdata;
      if (wr && hit(bus_addr, OFF_PTBASE)) ptbase_q <= bus_wdata;
    end
  end

  // window k: start at OFF_WIN0 + 8k, inclusive end at OFF_WIN0 + 8k + 4
  for (genvar k = 0; k < NUM_WREG; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) win_q[k] <= '0;
      else if (wr && hit(bus_addr, OFF_WIN0 + 4 * k)) win_q[k] <= bus_wdata;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFF_CTRL))   rd_mux = {29'b0, ctrl_q};
    if (hit(bus_addr, OFF_CFG))    rd_mux = cfg_q;
    if (hit(bus_addr, OFF_STAT))   rd_mux = {31'b0, xlat_blocked};
    if (hit(bus_addr, OFF_PTBASE)) rd_mux = ptbase_q;
    if (hit(bus_addr, OFF_ISTAT))  rd_mux = {{(32-NUM_FTYPES){1'b0}}, istat};
    if (hit(bus_addr, OFF_VER))    rd_mux = VERSION;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (hit(bus_addr, OFF_FADDR0 + 4 * s)) rd_mux = faddr[s];
    for (int k = 0; k < NUM_WREG; k++)
      if (hit(bus_addr, OFF_WIN0 + 4 * k)) rd_mux = win_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R3
  stat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && hit(bus_addr, OFF_STAT)) |=> (bus_rdata[0] == $past(xlat_blocked)));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_mmu_ctrl_regs.sv
module sim_mmu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        flt_valid = 0;
  logic [2:0]  flt_type = 0;
  logic [31:0] flt_addr = 0;
  logic        xlat_en, xlat_blocked, irq, flush_all, flush_one;
  logic [31:0] flush_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_st = 0;
  logic [31:0] m_addr [4];

  always #2 clk = ~clk;  // 250 MHz

  mmu_ctrl_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(req, bus_rdata, exp);
  endtask

  function automatic int slot_of(input int t);
    case (t)
      0: return 0;
      2, 6, 7: return 1;
      3: return 3;
      default: return 2;
    endcase
  endfunction

  // fault, optionally with a clear write in the same cycle
  task automatic fault(input int t, input logic [31:0] a, input bit with_clr, input logic [7:0] m);
    @(negedge clk);
    flt_valid = 1; flt_type = 3'(t); flt_addr = a;
    if (with_clr) begin bus_sel = 1; bus_we = 1; bus_addr = 8'h1C; bus_wdata = {24'b0, m}; end
    @(negedge clk);
    flt_valid = 0; bus_sel = 0; bus_we = 0;
    if (!m_st[t]) m_addr[slot_of(t)] = a;
    if (with_clr) m_st = m_st & ~m;
    m_st[t] = 1'b1;
  endtask

  task automatic clr(input logic [7:0] m);
    wr(8'h1C, {24'b0, m});
    m_st = m_st & ~m;
  endtask

  task automatic check_log(input string req);
    rd(8'h18, {24'b0, m_st}, req);
    for (int s = 0; s < 4; s++) rd(8'h24 + 8'(4 * s), m_addr[s], req);
    chk(req, {31'b0, irq}, {31'b0, |m_st});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    for (int s = 0; s < 4; s++) m_addr[s] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1", {27'b0, xlat_en, xlat_blocked, irq, flush_all, flush_one}, 0);
    rd(8'h00, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h18, 0, "R1");
    rd(8'h14, 0, "R1"); rd(8'h24, 0, "R1"); rd(8'h4C, 0, "R1");
    rd(8'h34, 32'h3000_0001, "R1");
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h3000_0001, "R1");

    // R2 enable / disable
    wr(8'h00, 5); chk("R2", xlat_en, 1); rd(8'h00, 5, "R2");
    wr(8'h00, 0); chk("R2", xlat_en, 0); rd(8'h00, 0, "R2");
    wr(8'h00, 5);

    // R3 block handshake
    wr(8'h00, 7); chk("R3", xlat_blocked, 1); rd(8'h08, 1, "R3");
    chk("R3", xlat_en, 1);
    wr(8'h00, 5); chk("R3", xlat_blocked, 0); rd(8'h08, 0, "R3");

    // R11 plain registers, R12 unmapped
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = (i == 0) ? 8'h04 : (i == 1) ? 8'h14 : 8'h4C + 8'(4 * (i - 2));
      d = $urandom;
      wr(a, d);
      rd(a, d, "R11");
    end
    rd(8'h40, 0, "R12"); rd(8'h0C, 0, "R12"); rd(8'h10, 0, "R12");

    // R9 full flush pulse
    wr(8'h0C, 1); chk("R9", flush_all, 1);
    @(negedge clk); chk("R9", flush_all, 0);
    wr(8'h0C, 2); chk("R9", flush_all, 0);

    // R10 page flush
    wr(8'h10, 32'hABCD_E7F1); chk("R10", flush_one, 1);
    chk("R10", flush_addr, 32'hABCD_E000);
    @(negedge clk); chk("R10", flush_one, 0);
    wr(8'h10, 32'h1234_5000); chk("R10", flush_one, 0);

    // R4 fault blocks until 0x5
    fault(0, 32'h1000_0123, 0, 0);
    chk("R4", xlat_blocked, 1); chk("R5", irq, 1);
    wr(8'h00, 7); chk("R4", xlat_blocked, 1);
    wr(8'h00, 0); chk("R4", xlat_blocked, 1);
    wr(8'h00, 5); chk("R4", xlat_blocked, 0);

    // R6/R7 repeat fault keeps address
    fault(0, 32'h2000_0456, 0, 0);
    rd(8'h24, 32'h1000_0123, "R7");
    clr(8'h01);
    fault(0, 32'h2000_0456, 0, 0);
    rd(8'h24, 32'h2000_0456, "R7");

    // R8 clear and fault same bit same cycle: bit stays
    fault(3, 32'h3333_0000, 0, 0);
    fault(3, 32'h4444_0000, 1, 8'h08);
    rd(8'h18, {24'b0, m_st}, "R8");
    rd(8'h30, 32'h3333_0000, "R8");
    wr(8'h18, 0);
    rd(8'h18, {24'b0, m_st}, "R8");
    clr(8'hFF);
    check_log("R8");

    // R5/R6/R7/R8 random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) fault($urandom_range(0, 7), $urandom, 0, 0);
      else if (op < 7) clr(8'($urandom));
      else if (op == 7) fault($urandom_range(0, 7), $urandom, 1, 8'($urandom));
      else check_log("R6");
    end
    check_log("R5");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule